// File: doc/BRIEF.md
# Gate Driver Protection Sequencer

This block is the digital control core of a single-channel power-switch gate driver. It takes a logic command and four comparator flags that have already been digitized: supply above its start level, supply below its drop level, desaturation sense above threshold, and over-temperature. From these it produces the gate-on command, an active-low fault indication, and a select that either holds the desaturation blanking node discharged or lets it charge. All intervals are counted in clock cycles.

The command first passes through a pulse-width filter, so short glitches never reach the gate. Supply and temperature faults are handled in two stages. After a first delay the fault indication asserts, which warns the host controller. After a longer grace delay the gate is forced off, so the controller has time to shut the system down in order. A desaturation fault takes a faster path: once the blanking count that follows each turn-on has expired, it turns the gate off on the next clock and latches that state until the command goes low.

The analog comparators, the reference and the output power stage are outside this block.

Top module: `gate_prot_seq`

## Requirements
- R1: During and right after reset, gate_on is 0, fault_n is 1 (released) and desat_discharge is 1.
- R2: With no fault active and supply enabled, gate_on equals the filtered command, and it is in phase with cmd_in (1 = on).
- R3: A cmd_in level must be held for MIN_PW consecutive clock edges before the filtered command takes it. A level held for fewer edges causes no change at gate_on.
- R4: After reset, gate_on stays 0 whatever cmd_in does, until sup_above_on is seen at a clock edge. fault_n stays released during this startup hold.
- R5: When sup_below_off is seen at edge e0 while running, fault_n goes to 0 after edge e0+FLT_DLY and gate_on is forced to 0 after edge e0+FLT_DLY+GRACE_DLY.
- R6: Once the gate has been forced off by low supply, it stays off, with fault_n held at 0, until sup_above_on is seen. It is then released on that edge.
- R7: If sup_above_on is seen while the fault delay or the grace delay is running, the shutdown is cancelled. fault_n reads 1 and the gate follows the command after that edge.
- R8: An over-temperature flag follows the same two-stage timing as R5. The block resumes on the first edge at which over_temp is 0.
- R9: desat_discharge is 1 whenever the gate is off. After each turn-on, desat_hi is ignored for max(blank_cycles,1) edges, counted from the edge after the gate rises.
- R10: desat_hi seen after blanking, while the gate is on, drives gate_on to 0 and fault_n to 0 on that same edge.
- R11: A desaturation trip keeps the gate off and fault_n at 0 until the filtered command is low. fault_n is released one edge later.
- R12: When no fault is active, fault_n is 1 whether the command is low or high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Logic gate command (1 = on) |
| sup_above_on | input | 1 | Supply is above its start threshold |
| sup_below_off | input | 1 | Supply is below its drop threshold |
| desat_hi | input | 1 | Desaturation sense is above threshold |
| over_temp | input | 1 | Die temperature is above its trip point (hysteresis is applied outside the block) |
| blank_cycles | input | BLANK_W | Blanking length in cycles; 0 is treated as 1 |
| gate_on | output | 1 | Gate drive command |
| fault_n | output | 1 | Fault, active low; 1 means the open-drain output is released |
| desat_discharge | output | 1 | 1 holds the blanking node discharged; 0 lets it charge |

## Verification
The bench targets the following corner cases:
- Command pulses one edge short of the filter width, which must not appear at the gate.
- The exact edges at which the fault and the forced-off state arrive after a supply drop or an over-temperature flag. A design that merged the two delays, or skipped the warning stage, would cut the gate with no notice to the host.
- Supply recovery in the middle of each delay. A design that ignored it would shut down a healthy system.
- A desaturation flag raised during blanking, at the last edge of blanking, and just after it. An off-by-one here either trips falsely while the switch is still turning on, or reacts late.
- The desaturation latch held while the command stays high. A weak latch would let the gate restart into a short circuit.

// File: rtl/gps_pkg.sv
package gps_pkg;

    typedef enum logic [2:0] {
        SQ_RUN   = 3'd0,
        SQ_WAIT  = 3'd1,
        SQ_GRACE = 3'd2,
        SQ_OFF   = 3'd3,
        SQ_LOCK  = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_BLANK = 2'd1,
        DS_ARMED = 2'd2,
        DS_TRIP  = 2'd3
    } dsat_st_e;

    typedef struct packed {
        logic flag;
        logic force_off;
    } seq_out_t;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gps_in_filter.sv
module gps_in_filter
    import gps_pkg::*;
#(
    parameter int MIN_PW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_in,
    output logic cmd_f
);
    localparam int CW = cnt_width(MIN_PW);
    localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_f   <= 1'b0;
            run_cnt <= '0;
        end else if (cmd_in == cmd_f) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            cmd_f   <= cmd_in;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    p_change_needs_input_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_f != $past(cmd_f)) |-> (cmd_f == $past(cmd_in)));

endmodule

// File: rtl/gps_grace_seq.sv
module gps_grace_seq
    import gps_pkg::*;
#(
    parameter int FLT_DLY      = 1825,
    parameter int GRACE_DLY    = 3000,
    parameter bit START_LOCKED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     trip,
    input  logic     clear,
    output seq_out_t st_o
);
    localparam int CW = cnt_width(max2(FLT_DLY, GRACE_DLY));
    localparam logic [CW-1:0] FLT_LAST   = CW'(FLT_DLY - 1);
    localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE_DLY - 1);

    seq_st_e       st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= START_LOCKED ? SQ_LOCK : SQ_RUN;
            cnt <= '0;
        end else begin
            unique case (st)
                SQ_RUN: begin
                    cnt <= '0;
                    if (trip) st <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (clear) begin
                        st <= SQ_RUN;
                    end else if (cnt == FLT_LAST) begin
                        st  <= SQ_GRACE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GRACE: begin
                    if (clear) begin
                        st <= SQ_RUN;
                    end else if (cnt == GRACE_LAST) begin
                        st  <= SQ_OFF;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_OFF, SQ_LOCK: begin
                    cnt <= '0;
                    if (clear) st <= SQ_RUN;
                end
                default: st <= SQ_RUN;
            endcase
        end
    end

    always_comb begin
        st_o.flag      = (st == SQ_GRACE) || (st == SQ_OFF);
        st_o.force_off = (st == SQ_OFF) || (st == SQ_LOCK);
    end

    p_force_after_flag_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_o.force_off) |-> $past(st_o.flag));

    p_clear_cancels_r7: assert property (@(posedge clk) disable iff (rst)
        (clear && st_o.flag) |=> !st_o.flag);

endmodule

// File: rtl/gps_desat_mon.sv
module gps_desat_mon
    import gps_pkg::*;
#(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gate_on,
    input  logic               cmd_f,
    input  logic               desat_hi,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic               tripped,
    output logic               discharge
);
    dsat_st_e           st;
    logic [BLANK_W-1:0] cnt;
    logic [BLANK_W-1:0] blank_last;

    assign blank_last = (blank_cycles == '0) ? '0 : blank_cycles - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= DS_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                DS_IDLE: begin
                    cnt <= '0;
                    if (gate_on) st <= DS_BLANK;
                end
                DS_BLANK: begin
                    if (!gate_on) begin
                        st <= DS_IDLE;
                    end else if (cnt >= blank_last) begin
                        st <= DS_ARMED;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                DS_ARMED: begin
                    if (!gate_on)     st <= DS_IDLE;
                    else if (desat_hi) st <= DS_TRIP;
                end
                DS_TRIP: begin
                    cnt <= '0;
                    if (!cmd_f) st <= DS_IDLE;
                end
                default: st <= DS_IDLE;
            endcase
        end
    end

    assign tripped   = (st == DS_TRIP);
    assign discharge = !((st == DS_BLANK) || (st == DS_ARMED));

    p_discharge_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !gate_on |=> discharge);

    p_trip_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tripped) |-> ($past(desat_hi) && $past(gate_on)));

endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq
    import gps_pkg::*;
#(
    parameter int MIN_PW    = 4,
    parameter int FLT_DLY   = 1825,
    parameter int GRACE_DLY = 3000,
    parameter int BLANK_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_in,
    input  logic               sup_above_on,
    input  logic               sup_below_off,
    input  logic               desat_hi,
    input  logic               over_temp,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic               gate_on,
    output logic               fault_n,
    output logic               desat_discharge
);
    localparam int NSEQ = 2;

    logic            cmd_f;
    logic            ds_trip;
    logic [NSEQ-1:0] seq_trip;
    logic [NSEQ-1:0] seq_clear;
    seq_out_t        seq_o [NSEQ];
    logic            any_flag;
    logic            any_force;

    gps_in_filter #(.MIN_PW(MIN_PW)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .cmd_in (cmd_in),
        .cmd_f  (cmd_f)
    );

    // lane 0: supply monitor (starts locked); lane 1: thermal monitor
    assign seq_trip[0]  = sup_below_off;
    assign seq_clear[0] = sup_above_on;
    assign seq_trip[1]  = over_temp;
    assign seq_clear[1] = !over_temp;

    for (genvar i = 0; i < NSEQ; i++) begin : g_seq
        gps_grace_seq #(
            .FLT_DLY      (FLT_DLY),
            .GRACE_DLY    (GRACE_DLY),
            .START_LOCKED (i == 0)
        ) u_seq (
            .clk   (clk),
            .rst   (rst),
            .trip  (seq_trip[i]),
            .clear (seq_clear[i]),
            .st_o  (seq_o[i])
        );
    end

    always_comb begin
        any_flag  = 1'b0;
        any_force = 1'b0;
        for (int i = 0; i < NSEQ; i++) begin
            any_flag  = any_flag  | seq_o[i].flag;
            any_force = any_force | seq_o[i].force_off;
        end
    end

    gps_desat_mon #(.BLANK_W(BLANK_W)) u_dsat (
        .clk          (clk),
        .rst          (rst),
        .gate_on      (gate_on),
        .cmd_f        (cmd_f),
        .desat_hi     (desat_hi),
        .blank_cycles (blank_cycles),
        .tripped      (ds_trip),
        .discharge    (desat_discharge)
    );

    assign gate_on = cmd_f && !any_force && !ds_trip;
    assign fault_n = !(any_flag || ds_trip);

    p_startup_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(sup_above_on)) |-> !gate_on);

    p_gate_off_on_trip_r10: assert property (@(posedge clk) disable iff (rst)
        !fault_n && $past(!fault_n) && $past(gate_on) && !any_flag |-> !gate_on);

endmodule

// File: tb/sim_gate_prot_seq.sv
module sim_gate_prot_seq;
    localparam int MIN_PW = 4;
    localparam int FLT    = 20;
    localparam int GRACE  = 40;
    localparam int BW     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_in = 0, sup_above_on = 0, sup_below_off = 0, desat_hi = 0, over_temp = 0;
    logic [BW-1:0] blank_cycles = BW'(10);
    logic gate_on, fault_n, desat_discharge;

    always #2 clk = ~clk;

    gate_prot_seq #(.MIN_PW(MIN_PW), .FLT_DLY(FLT), .GRACE_DLY(GRACE), .BLANK_W(BW)) u0 (
        .clk(clk), .rst(rst), .cmd_in(cmd_in), .sup_above_on(sup_above_on),
        .sup_below_off(sup_below_off), .desat_hi(desat_hi), .over_temp(over_temp),
        .blank_cycles(blank_cycles), .gate_on(gate_on), .fault_n(fault_n),
        .desat_discharge(desat_discharge));

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    string cur_tag = "R1";

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model: 0 run, 1 wait, 2 grace, 3 off, 4 lock ; desat 0 idle,1 blank,2 armed,3 trip
    int mf, mcnt, ds, dcnt;
    int ss[2], sc[2];

    function automatic bit m_flag(int s);  return s == 2 || s == 3; endfunction
    function automatic bit m_force(int s); return s == 3 || s == 4; endfunction
    function automatic bit m_gate();
        return (mf != 0) && !m_force(ss[0]) && !m_force(ss[1]) && ds != 3;
    endfunction
    function automatic bit m_fault_n();
        return !(m_flag(ss[0]) || m_flag(ss[1]) || ds == 3);
    endfunction
    function automatic bit m_dis(); return !(ds == 1 || ds == 2); endfunction

    function automatic void seq_step(int k, bit trip, bit clr);
        case (ss[k])
            0: begin sc[k] = 0; if (trip) ss[k] = 1; end
            1: if (clr) ss[k] = 0; else if (sc[k] == FLT - 1) begin ss[k] = 2; sc[k] = 0; end else sc[k]++;
            2: if (clr) ss[k] = 0; else if (sc[k] == GRACE - 1) begin ss[k] = 3; sc[k] = 0; end else sc[k]++;
            default: if (clr) ss[k] = 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mf = 0; mcnt = 0; ds = 0; dcnt = 0;
            ss[0] = 4; ss[1] = 0; sc[0] = 0; sc[1] = 0;
        end else begin
            automatic bit g = m_gate();
            automatic int old_f = mf;
            automatic int blen = (blank_cycles == 0) ? 1 : int'(blank_cycles);
            if (int'(cmd_in) != mf) begin
                mcnt++;
                if (mcnt == MIN_PW) begin mf = int'(cmd_in); mcnt = 0; end
            end else mcnt = 0;
            seq_step(0, sup_below_off, sup_above_on);
            seq_step(1, over_temp, !over_temp);
            case (ds)
                0: begin dcnt = 0; if (g) ds = 1; end
                1: if (!g) ds = 0; else if (dcnt >= blen - 1) ds = 2; else dcnt++;
                2: if (!g) ds = 0; else if (desat_hi) ds = 3;
                default: if (old_f == 0) ds = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_tag, "gate_on", gate_on, m_gate());
            chk(cur_tag, "fault_n", fault_n, m_fault_n());
            chk(cur_tag, "desat_discharge", desat_discharge, m_dis());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd5705));
        step(3);
        chk("R1", "gate_on", gate_on, 1'b0);
        chk("R1", "fault_n", fault_n, 1'b1);
        chk("R1", "desat_discharge", desat_discharge, 1'b1);
        rst = 0;
        cmd_in = 1;
        cur_tag = "R4";
        step(20);
        chk("R4", "gate held", gate_on, 1'b0);
        chk("R4", "fault released", fault_n, 1'b1);
        sup_above_on = 1;
        step(1);
        chk("R4", "gate after enable", gate_on, 1'b1);
        // R3 short pulse
        cur_tag = "R3";
        cmd_in = 0; step(MIN_PW - 1); cmd_in = 1; step(5);
        chk("R3", "short low ignored", gate_on, 1'b1);
        cmd_in = 0; step(MIN_PW);
        chk("R3", "full low passes", gate_on, 1'b0);
        cur_tag = "R12";
        chk("R12", "released when low", fault_n, 1'b1);
        cmd_in = 1; step(MIN_PW);
        chk("R2", "gate follows high", gate_on, 1'b1);
        chk("R12", "released when high", fault_n, 1'b1);
        step(30);
        // R5 supply drop
        cur_tag = "R5";
        sup_above_on = 0; sup_below_off = 1;
        step(FLT);
        chk("R5", "fault before delay", fault_n, 1'b1);
        step(1);
        chk("R5", "fault after delay", fault_n, 1'b0);
        step(GRACE - 1);
        chk("R5", "gate during grace", gate_on, 1'b1);
        step(1);
        chk("R5", "gate forced off", gate_on, 1'b0);
        cur_tag = "R6";
        sup_below_off = 0;
        step(10);
        chk("R6", "stays off between levels", gate_on, 1'b0);
        chk("R6", "fault held", fault_n, 1'b0);
        sup_above_on = 1;
        step(1);
        chk("R6", "fault released", fault_n, 1'b1);
        chk("R6", "gate back", gate_on, 1'b1);
        step(30);
        // R7 cancel
        cur_tag = "R7";
        sup_above_on = 0; sup_below_off = 1; step(10);
        sup_above_on = 1; sup_below_off = 0; step(1);
        chk("R7", "cancel in first delay fault", fault_n, 1'b1);
        chk("R7", "cancel in first delay gate", gate_on, 1'b1);
        sup_above_on = 0; sup_below_off = 1; step(FLT + 5);
        chk("R7", "fault in grace", fault_n, 1'b0);
        sup_above_on = 1; sup_below_off = 0; step(1);
        chk("R7", "cancel in grace fault", fault_n, 1'b1);
        chk("R7", "cancel in grace gate", gate_on, 1'b1);
        step(30);
        // R8 thermal
        cur_tag = "R8";
        over_temp = 1;
        step(FLT + 1);
        chk("R8", "thermal fault", fault_n, 1'b0);
        chk("R8", "gate still on", gate_on, 1'b1);
        step(GRACE);
        chk("R8", "thermal gate off", gate_on, 1'b0);
        over_temp = 0;
        step(1);
        chk("R8", "thermal resume gate", gate_on, 1'b1);
        chk("R8", "thermal resume fault", fault_n, 1'b1);
        // R9 R10 R11 desaturation
        cur_tag = "R9";
        cmd_in = 0; step(10);
        chk("R9", "discharge while off", desat_discharge, 1'b1);
        cmd_in = 1; step(MIN_PW);
        chk("R9", "gate rose", gate_on, 1'b1);
        desat_hi = 1;
        step(1);
        chk("R9", "charging in blank", desat_discharge, 1'b0);
        step(10);
        chk("R9", "desat ignored in blank", gate_on, 1'b1);
        cur_tag = "R10";
        step(1);
        chk("R10", "gate off on desat", gate_on, 1'b0);
        chk("R10", "fault on desat", fault_n, 1'b0);
        cur_tag = "R11";
        desat_hi = 0; step(10);
        chk("R11", "latched gate", gate_on, 1'b0);
        chk("R11", "latched fault", fault_n, 1'b0);
        cmd_in = 0; step(MIN_PW);
        chk("R11", "fault held until cmd low seen", fault_n, 1'b0);
        step(1);
        chk("R11", "fault released", fault_n, 1'b1);
        // random phase checked by model
        cur_tag = "R2";
        begin
            int run = 0;
            for (int i = 0; i < 6000; i++) begin
                automatic int r = $urandom % 1000;
                if (run == 0) begin cmd_in = ~cmd_in; run = $urandom_range(1, 14); end
                run--;
                if (r < 3)      begin sup_above_on = 0; sup_below_off = 1; end
                else if (r < 7) begin sup_above_on = 1; sup_below_off = 0; end
                else if (r < 9) begin sup_above_on = 0; sup_below_off = 0; end
                if ($urandom % 500 == 0) over_temp = ~over_temp;
                desat_hi = ($urandom % 16 == 0);
                if (i % 500 == 0) blank_cycles = BW'($urandom % 16);
                step(1);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule